// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block exchanges stereo audio samples between a parallel core and one serial input line and one serial output line. An external bit clock and word clock time the transfer. Both clocks arrive as plain inputs. The block samples them in its own system clock domain and works from their edges, so it contains no second clock domain. One framing engine serves three placements of the sample inside each channel slot:

- **Left-justified:** the word starts at the word-clock edge.
- **I2S-style:** the word starts one bit later, and the word-clock polarity is inverted.
- **Right-justified:** the word ends at the next word-clock edge.

Static configuration inputs select the placement, the word length (16, 18, 20 or 24 bits) and the frame size (32 or 64 bit clocks). They must not change during a frame.

The receiver collects the left word and then the right word. After the right word it presents both on 24-bit outputs, either sign-extended or left-aligned, with a one-cycle valid pulse. The transmitter takes two MSB-aligned 24-bit words at the start of each frame and shifts them out MSB first. It drives zero in every slot that carries no data.

Top module: `aport_top`

## Requirements
- R1: While reset is asserted and until the first bit-clock activity after reset, `sdout`, `rx_valid`, `rx_left` and `rx_right` are all zero.
- R2: With `cfg_fmt`=0 (left-justified), the MSB occupies the first bit-clock slot after a word-clock transition, and word clock high marks the left channel.
- R3: With `cfg_fmt`=1 (I2S-style), the MSB occupies the second slot after a word-clock transition, and word clock low marks the left channel.
- R4: With `cfg_fmt`=2 (right-justified), the LSB occupies the last slot before the next word-clock transition, so the first data slot of a half-frame is its slot count minus the word length.
- R5: With `cfg_frame64`=1 each channel has 32 bit-clock slots; with 0 it has 16 slots and carries 16-bit words only.
- R6: `cfg_wlen` codes 0, 1, 2 and 3 select word lengths of 16, 18, 20 and 24 bits.
- R7: Serial input is sampled on rising bit-clock edges. `sdout` changes only after falling edges, so it changes only while the bit clock is low.
- R8: In slots outside the data window the transmitter drives 0 and the receiver ignores the line.
- R9: With `cfg_sext`=1 a received word is sign-extended into 24 bits. With `cfg_sext`=0 it is left-aligned with zeros in the unused low bits.
- R10: `rx_valid` pulses for exactly one cycle once per frame, after the right word completes. `rx_left` and `rx_right` change only in that cycle.
- R11: `tx_left` and `tx_right` are sampled at the first slot of each frame's left channel. They are MSB-aligned: bit 23 is sent first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Placement: 0 left-justified, 1 I2S-style, 2 right-justified |
| cfg_wlen | input | 2 | Word length code (16/18/20/24 bits) |
| cfg_frame64 | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| cfg_sext | input | 1 | 1: sign-extend received words, 0: left-align them |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Left/right word clock |
| sdin | input | 1 | Serial data in |
| tx_left | input | 24 | Left word to send, MSB-aligned |
| tx_right | input | 24 | Right word to send, MSB-aligned |
| sdout | output | 1 | Serial data out |
| rx_left | output | 24 | Last received left word |
| rx_right | output | 24 | Last received right word |
| rx_valid | output | 1 | One-cycle strobe marking a new received pair |

## Verification
The assertions assume the following about the inputs:

- Each bit-clock phase lasts several system clocks, so that `sdout`, updated a few cycles after a falling edge, settles before the clock rises again.
- The configuration holds steady while a frame is in flight.
- Frames carry the advertised number of bit clocks.

The stimulus keeps within these limits in four ways. It holds each bit-clock phase for six system clocks. It changes configuration only between frames. It generates exactly 32 or 64 slots per frame. It scores the frames that follow a configuration change only after one frame has been discarded for resynchronisation. Noise is driven into unused input slots so that leakage into the received words shows up.

// File: rtl/aport_pkg.sv
package aport_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_RJ  = 2'd2,
      FMT_RSV = 2'd3
   } fmt_e;

   // word length code to bit count
   function automatic logic [5:0] wlen_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 6'd16;
         2'd1:    return 6'd18;
         2'd2:    return 6'd20;
         default: return 6'd24;
      endcase
   endfunction

endpackage

// File: rtl/aport_sync.sv
module aport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic wclk,
   input  logic sdin,
   output logic b_s,
   output logic w_s,
   output logic d_s,
   output logic b_rise,
   output logic b_fall
);
   logic [2:0] raw;
   logic [2:0] tap;
   logic       b_prev;

   assign raw = {bclk, wclk, sdin};

   generate
      if (STAGES == 0) begin : g_direct
         assign tap = raw;
      end else if (STAGES == 1) begin : g_one
         logic [2:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= raw;
         end
         assign tap = q;
      end else begin : g_chain
         logic [3*STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[3*STAGES-4:0], raw};
         end
         assign tap = q[3*STAGES-1 -: 3];
      end
   endgenerate

   assign {b_s, w_s, d_s} = tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_prev <= 1'b0;
      else        b_prev <= b_s;
   end

   assign b_rise = b_s & ~b_prev;
   assign b_fall = ~b_s & b_prev;

endmodule

// File: rtl/aport_slot.sv
module aport_slot #(
   parameter int KW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          b_rise,
   input  logic          b_fall,
   input  logic          w_s,
   input  logic          i2s,
   input  logic [KW-1:0] half,
   output logic [KW-1:0] k,
   output logic          left,
   output logic [KW-1:0] nxt_k,
   output logic          nxt_left
);
   localparam logic [KW-1:0] SAT = '1;

   logic w_at_rise;

   // Slot index and channel for the coming rising edge, decided at the falling edge.
   // I2S-style: the word clock seen at the previous rise, inverted, acts as an
   // effective left-justified word clock one bit late.
   always_comb begin
      nxt_k    = k;
      nxt_left = left;
      if (b_fall) begin
         nxt_left = i2s ? ~w_at_rise : w_s;
         if (nxt_left != left)          nxt_k = '0;
         else if (k >= half - KW'(1))   nxt_k = SAT;
         else                           nxt_k = k + KW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         k         <= SAT;
         left      <= 1'b0;
         w_at_rise <= 1'b0;
      end else begin
         k    <= nxt_k;
         left <= nxt_left;
         if (b_rise) w_at_rise <= w_s;
      end
   end

endmodule

// File: rtl/aport_rx.sv
module aport_rx #(
   parameter int OUT_W = 24,
   parameter int KW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_rise,
   input  logic             d_s,
   input  logic [KW-1:0]    k,
   input  logic             left,
   input  logic [KW-1:0]    win_s,
   input  logic [KW-1:0]    win_w,
   input  logic             sext,
   output logic [OUT_W-1:0] rx_left,
   output logic [OUT_W-1:0] rx_right,
   output logic             rx_valid
);
   logic [OUT_W-1:0] shreg, word, aligned, hold_l;
   logic             in_win, at_last;

   assign in_win  = (k >= win_s) && (k < win_s + win_w);
   assign at_last = (k == win_s + win_w - KW'(1));
   assign word    = {shreg[OUT_W-2:0], d_s};

   always_comb begin
      aligned = '0;
      if (sext) begin
         for (int i = 0; i < OUT_W; i++)
            aligned[i] = (i < int'(win_w)) ? word[i] : word[int'(win_w) - 1];
      end else begin
         aligned = word << (OUT_W - int'(win_w));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         hold_l   <= '0;
         rx_left  <= '0;
         rx_right <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (b_rise && in_win) begin
            shreg <= word;
            if (at_last) begin
               if (left) begin
                  hold_l <= aligned;
               end else begin
                  rx_left  <= hold_l;
                  rx_right <= aligned;
                  rx_valid <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/aport_tx.sv
module aport_tx #(
   parameter int OUT_W = 24,
   parameter int KW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_fall,
   input  logic [KW-1:0]    nxt_k,
   input  logic             nxt_left,
   input  logic [KW-1:0]    win_s,
   input  logic [KW-1:0]    win_w,
   input  logic [OUT_W-1:0] tx_left,
   input  logic [OUT_W-1:0] tx_right,
   output logic             sdout
);
   logic [OUT_W-1:0] hold_l, hold_r, cur;
   logic [KW-1:0]    off;
   logic             in_win, frame_start, bit_val;

   assign frame_start = nxt_left && (nxt_k == '0);
   assign cur         = nxt_left ? (frame_start ? tx_left : hold_l) : hold_r;
   assign off         = nxt_k - win_s;
   assign in_win      = (nxt_k >= win_s) && (nxt_k < win_s + win_w);
   assign bit_val     = in_win ? cur[OUT_W - 1 - int'(off)] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l <= '0;
         hold_r <= '0;
         sdout  <= 1'b0;
      end else if (b_fall) begin
         if (frame_start) begin
            hold_l <= tx_left;
            hold_r <= tx_right;
         end
         sdout <= bit_val;
      end
   end

endmodule

// File: rtl/aport_top.sv
module aport_top import aport_pkg::*; #(
   parameter int OUT_W       = 24,
   parameter int HALF_LONG   = 32,
   parameter int HALF_SHORT  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_wlen,
   input  logic             cfg_frame64,
   input  logic             cfg_sext,
   input  logic             bclk,
   input  logic             wclk,
   input  logic             sdin,
   input  logic [OUT_W-1:0] tx_left,
   input  logic [OUT_W-1:0] tx_right,
   output logic             sdout,
   output logic [OUT_W-1:0] rx_left,
   output logic [OUT_W-1:0] rx_right,
   output logic             rx_valid
);
   localparam int KW = $clog2(HALF_LONG) + 1;

   generate
      if (OUT_W < 24 || OUT_W > 32) begin : g_bad_out_w
         $error("aport_top: OUT_W must lie in 24..32");
      end
      if (HALF_LONG < 24) begin : g_bad_long
         $error("aport_top: HALF_LONG must hold a 24-bit word");
      end
      if (HALF_SHORT < 16 || HALF_SHORT > HALF_LONG) begin : g_bad_short
         $error("aport_top: HALF_SHORT must lie in 16..HALF_LONG");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("aport_top: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic          b_s, w_s, d_s, b_rise, b_fall;
   logic [KW-1:0] half, win_w, win_s, k, nxt_k;
   logic          left, nxt_left, i2s;

   assign i2s   = (cfg_fmt == FMT_I2S);
   assign half  = cfg_frame64 ? KW'(HALF_LONG) : KW'(HALF_SHORT);
   assign win_w = KW'(wlen_bits(cfg_wlen));
   assign win_s = (cfg_fmt == FMT_RJ) ? half - win_w : '0;

   aport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
      .b_s(b_s), .w_s(w_s), .d_s(d_s), .b_rise(b_rise), .b_fall(b_fall)
   );

   aport_slot #(.KW(KW)) u_slot (
      .clk(clk), .rst_n(rst_n), .b_rise(b_rise), .b_fall(b_fall),
      .w_s(w_s), .i2s(i2s), .half(half),
      .k(k), .left(left), .nxt_k(nxt_k), .nxt_left(nxt_left)
   );

   aport_rx #(.OUT_W(OUT_W), .KW(KW)) u_rx (
      .clk(clk), .rst_n(rst_n), .b_rise(b_rise), .d_s(d_s),
      .k(k), .left(left), .win_s(win_s), .win_w(win_w), .sext(cfg_sext),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
   );

   aport_tx #(.OUT_W(OUT_W), .KW(KW)) u_tx (
      .clk(clk), .rst_n(rst_n), .b_fall(b_fall),
      .nxt_k(nxt_k), .nxt_left(nxt_left), .win_s(win_s), .win_w(win_w),
      .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout)
   );

   logic unused_b_s;
   assign unused_b_s = b_s;

endmodule

// File: rtl/aport_chk.sv
module aport_chk import aport_pkg::*; #(
   parameter int OUT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bclk,
   input logic [1:0]       cfg_wlen,
   input logic             cfg_sext,
   input logic             sdout,
   input logic [OUT_W-1:0] rx_left,
   input logic [OUT_W-1:0] rx_right,
   input logic             rx_valid
);
   int               w;
   logic [OUT_W-1:0] low_m, hi_m;

   always_comb begin
      w     = int'(wlen_bits(cfg_wlen));
      low_m = OUT_W'((64'd1 << (OUT_W - w)) - 64'd1);
      hi_m  = ~OUT_W'((64'd1 << (w - 1)) - 64'd1);
   end

   assert_sdout_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdout) |-> !bclk);

   assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_left_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_left));

   assert_right_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_right));

   assert_left_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_sext) |-> (((rx_left & low_m) == '0) && ((rx_right & low_m) == '0)));

   assert_sign_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && cfg_sext) |->
         ((((rx_left & hi_m) == '0) || ((rx_left & hi_m) == hi_m)) &&
          (((rx_right & hi_m) == '0) || ((rx_right & hi_m) == hi_m))));

endmodule

bind aport_top aport_chk #(.OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bclk(bclk), .cfg_wlen(cfg_wlen), .cfg_sext(cfg_sext),
   .sdout(sdout), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
);

// File: tb/tb_aport_top.sv
`timescale 1ns/1ps
module tb_aport_top;
   localparam int HS           = 6;
   localparam int WATCHDOG_CYC = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic [1:0]  cfg_wlen = 2'd0;
   logic        cfg_frame64 = 1'b1;
   logic        cfg_sext = 1'b0;
   logic        bclk = 1'b0;
   logic        wclk = 1'b0;
   logic        sdin = 1'b0;
   logic [23:0] tx_left = '0;
   logic [23:0] tx_right = '0;
   logic        sdout;
   logic [23:0] rx_left, rx_right;
   logic        rx_valid;

   int n_chk = 0;
   int n_bad = 0;
   int vcnt  = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   aport_top dut (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
      .cfg_frame64(cfg_frame64), .cfg_sext(cfg_sext), .bclk(bclk), .wclk(wclk),
      .sdin(sdin), .tx_left(tx_left), .tx_right(tx_right), .sdout(sdout),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
   );

   always @(negedge clk) if (rx_valid) vcnt++;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic int wbits(input int code);
      case (code)
         0: return 16;
         1: return 18;
         2: return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [23:0] exp_rx(input logic [23:0] wd, input int w, input bit sx);
      logic [23:0] m;
      logic [23:0] v;
      m = 24'((64'd1 << w) - 64'd1);
      if (sx) begin
         v = wd & m;
         if (wd[w-1]) v = v | ~m;
      end else begin
         v = wd << (24 - w);
      end
      return v;
   endfunction

   task automatic slot(input logic wb, input logic db, output logic so);
      @(negedge clk);
      bclk = 1'b0; wclk = wb; sdin = db;
      repeat (HS) @(negedge clk);
      so = sdout;
      bclk = 1'b1;
      repeat (HS - 1) @(negedge clk);
   endtask

   task automatic run_frame(input int fmt, input int code, input bit f64, input bit sx,
                            input int fidx, input bit do_chk);
      int          w, h, s, v0;
      logic [23:0] wl, wr, tl, tr, mask;
      logic [63:0] got, expv;
      string       tag;
      w    = wbits(code);
      h    = f64 ? 32 : 16;
      s    = (fmt == 2) ? h - w : 0;
      mask = 24'((64'd1 << w) - 64'd1);
      if (fidx == 1) begin
         wl = 24'(64'd1 << (w - 1));            // most negative word
         wr = 24'((64'd1 << (w - 1)) - 64'd1);  // most positive word
         tl = 24'h800001;
         tr = 24'h7ffffe;
      end else begin
         wl = 24'($urandom) & mask;
         wr = 24'($urandom) & mask;
         tl = 24'($urandom);
         tr = 24'($urandom);
      end
      tx_left  = tl;
      tx_right = tr;
      v0   = vcnt;
      got  = '0;
      expv = '0;
      for (int n = 0; n < 2 * h; n++) begin
         int          c, k;
         bit          inw;
         logic [23:0] dw, tw;
         logic        wb, db, so;
         c   = (n >= h) ? 1 : 0;
         k   = n - c * h;
         inw = (k >= s) && (k < s + w);
         dw  = c ? wr : wl;
         tw  = c ? tr : tl;
         db  = inw ? dw[w - 1 - (k - s)] : 1'($urandom);   // noise outside the window (R8)
         if (fmt == 1) wb = (((n + 1) % (2 * h)) < h) ? 1'b0 : 1'b1;
         else          wb = (n < h) ? 1'b1 : 1'b0;
         slot(wb, db, so);
         got[n]  = so;
         expv[n] = inw ? tw[23 - (k - s)] : 1'b0;
      end
      if (do_chk) begin
         tag = (fmt == 0) ? "R2" : (fmt == 1) ? "R3" : "R4";
         check(got == expv, {tag, " R5 R7 R8 R11"}, "tx frame bits", got, expv);
         check(rx_left == exp_rx(wl, w, sx), {tag, " R6 R8 R9"}, "rx left word",
               64'(rx_left), 64'(exp_rx(wl, w, sx)));
         check(rx_right == exp_rx(wr, w, sx), {tag, " R6 R8 R9"}, "rx right word",
               64'(rx_right), 64'(exp_rx(wr, w, sx)));
         check((vcnt - v0) == 1, "R10", "valid pulses in frame", 64'(vcnt - v0), 64'd1);
      end
   endtask

   task automatic run_config(input int fmt, input int code, input bit f64, input bit sx);
      cfg_fmt     = 2'(fmt);
      cfg_wlen    = 2'(code);
      cfg_frame64 = f64;
      cfg_sext    = sx;
      for (int f = 0; f < 3; f++) run_frame(fmt, code, f64, sx, f, f != 0);
   endtask

   initial begin
      void'($urandom(32'd48271));
      rst_n = 1'b0;
      repeat (8) @(negedge clk);
      check(sdout == 1'b0, "R1", "sdout in reset", 64'(sdout), 64'd0);
      check(rx_valid == 1'b0, "R1", "rx_valid in reset", 64'(rx_valid), 64'd0);
      check(rx_left == '0 && rx_right == '0, "R1", "rx words in reset",
            {16'd0, rx_left, rx_right}, 64'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(sdout == 1'b0 && rx_valid == 1'b0, "R1", "idle after reset",
            64'({sdout, rx_valid}), 64'd0);
      for (int fmt = 0; fmt < 3; fmt++)
         for (int code = 0; code < 4; code++)
            for (int sx = 0; sx < 2; sx++)
               run_config(fmt, code, 1'b1, sx[0]);
      for (int fmt = 0; fmt < 3; fmt++)
         for (int sx = 0; sx < 2; sx++)
            run_config(fmt, 0, 1'b0, sx[0]);   // R5 short frames, 16-bit words
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog expired: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule